// File: doc/BRIEF.md
# Cascaded Idle-Duration Timer

This block measures how long a serial bus line has stayed idle and raises millisecond-scale flags for a line-state controller. It runs on the 60 MHz transceiver clock. The timebase is built in three stages. A prescaler makes a 250 ns tick. A middle divider turns that into a 62.5 µs tick. A saturating coarse counter then counts the 62.5 µs ticks.

The coarse count is compared against fixed tick constants, and the results are held in registers as four flags:
- idle shorter than 3.0 ms;
- idle longer than 3.0 ms;
- idle longer than 3.125 ms;
- idle longer than 5.0 ms.

Two inputs restart the measurement. While the idle qualifier is low, or the synchronous clear is high, every stage is held at zero. The controller raises the qualifier once the line is idle and reads the flags to choose its next state.

Top module: `idle_duration_timer`

## Requirements
- R1: With counting enabled, the prescaler emits one tick every PRE_DIV clocks (default 15, giving 250 ns at 60 MHz), then wraps to zero.
- R2: The middle divider emits one tick for every MID_DIV prescaler ticks (default 250, giving 62.5 µs). So the coarse count reaches n exactly n·PRE_DIV·MID_DIV clocks after counting starts.
- R3: The coarse counter (CNT_W bits, default 8) adds one per middle tick and saturates at 2^CNT_W−1 (255) instead of wrapping. A long idle never reads as short.
- R4: While `idle_long_i` is 0 or `clr_i` is 1, all three stages become zero at the next clock edge.
- R5: `short_3ms_o` is 1 exactly when the coarse count one clock earlier was strictly less than 48.
- R6: `over_3ms_o` is 1 exactly when the coarse count one clock earlier was strictly greater than 48.
- R7: `over_3p125ms_o` is 1 exactly when the coarse count one clock earlier was strictly greater than 50.
- R8: `over_5ms_o` is 1 exactly when the coarse count one clock earlier was strictly greater than 80.
- R9: `rst_n` low clears all counters and all four flags at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transceiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_long_i | input | 1 | Idle qualifier; counting runs only while it is 1 |
| clr_i | input | 1 | Synchronous clear of all stages |
| short_3ms_o | output | 1 | Idle shorter than 3.0 ms |
| over_3ms_o | output | 1 | Idle longer than 3.0 ms |
| over_3p125ms_o | output | 1 | Idle longer than 3.125 ms |
| over_5ms_o | output | 1 | Idle longer than 5.0 ms |

## Verification
The bench shrinks the two dividers so that the thresholds and saturation can be reached in a short run. It then drives long uninterrupted idle runs, random drops of the qualifier and random clear pulses, comparing all four flags against a cycle model every clock. One directed run counts the exact clock on which the 3.0 ms flag rises, which tells a correct prescaler and divider apart from an off-by-one wrap. A second run idles far past 255 coarse ticks, which shows saturation as opposed to wrapping. Clears during idle, and a reset in the middle of a run, show that every stage restarts from zero and not only the flags.

// File: rtl/idle_timer_pkg.sv
package idle_timer_pkg;
  localparam int DEF_PRE_DIV  = 15;
  localparam int DEF_MID_DIV  = 250;
  localparam int DEF_CNT_W    = 8;
  localparam int DEF_TH_3MS   = 48;
  localparam int DEF_TH_3P125 = 50;
  localparam int DEF_TH_5MS   = 80;

  typedef struct packed {
    logic short_3ms;
    logic over_3ms;
    logic over_3p125ms;
    logic over_5ms;
  } idle_flags_t;
endpackage

// File: rtl/idle_tick_div.sv
module idle_tick_div #(
  parameter int DIV = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/idle_sat_counter.sv
module idle_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                    cnt_d = '0;
    else if (inc && cnt != CMAX) cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX) |=> (cnt == CMAX || cnt == '0));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt != CMAX) |=> (cnt == $past(cnt) + CNT_W'(1)));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/idle_thresh_cmp.sv
module idle_thresh_cmp
  import idle_timer_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TH_3MS   = 48,
  parameter int TH_3P125 = 50,
  parameter int TH_5MS   = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  output idle_flags_t      flags
);
  localparam logic [CNT_W-1:0] T3  = CNT_W'(TH_3MS);
  localparam logic [CNT_W-1:0] T31 = CNT_W'(TH_3P125);
  localparam logic [CNT_W-1:0] T5  = CNT_W'(TH_5MS);

  idle_flags_t flags_d;

  always_comb begin
    flags_d.short_3ms    = cnt < T3;
    flags_d.over_3ms     = cnt > T3;
    flags_d.over_3p125ms = cnt > T31;
    flags_d.over_5ms     = cnt > T5;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags.short_3ms && flags.over_3ms));
  assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flags.over_3p125ms |-> flags.over_3ms);
  assert_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags.over_5ms |-> flags.over_3p125ms);
  assert_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> (flags.short_3ms && !flags.over_3ms));
endmodule

// File: rtl/idle_duration_timer.sv
module idle_duration_timer
  import idle_timer_pkg::*;
#(
  parameter int PRE_DIV  = DEF_PRE_DIV,
  parameter int MID_DIV  = DEF_MID_DIV,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int TH_3MS   = DEF_TH_3MS,
  parameter int TH_3P125 = DEF_TH_3P125,
  parameter int TH_5MS   = DEF_TH_5MS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_long_i,
  input  logic clr_i,
  output logic short_3ms_o,
  output logic over_3ms_o,
  output logic over_3p125ms_o,
  output logic over_5ms_o
);
  logic             hold_zero;
  logic             run;
  logic             pre_tick;
  logic             mid_tick;
  logic [CNT_W-1:0] coarse;
  idle_flags_t      flags;

  assign hold_zero = !idle_long_i || clr_i;
  assign run       = !hold_zero;

  idle_tick_div #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(hold_zero), .en(run), .tick(pre_tick)
  );

  idle_tick_div #(.DIV(MID_DIV)) u_mid (
    .clk(clk), .rst_n(rst_n), .clr(hold_zero), .en(pre_tick), .tick(mid_tick)
  );

  idle_sat_counter #(.CNT_W(CNT_W)) u_coarse (
    .clk(clk), .rst_n(rst_n), .clr(hold_zero), .inc(mid_tick), .cnt(coarse)
  );

  idle_thresh_cmp #(
    .CNT_W(CNT_W), .TH_3MS(TH_3MS), .TH_3P125(TH_3P125), .TH_5MS(TH_5MS)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(coarse), .flags(flags)
  );

  assign short_3ms_o    = flags.short_3ms;
  assign over_3ms_o     = flags.over_3ms;
  assign over_3p125ms_o = flags.over_3p125ms;
  assign over_5ms_o     = flags.over_5ms;

  assert_cascade_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |-> pre_tick);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_zero |-> !pre_tick);
endmodule

// File: tb/idle_duration_timer_tb_top.sv
`timescale 1ns/1ps
module idle_duration_timer_tb_top;
  localparam int P = 3;
  localparam int M = 4;
  localparam int T = P * M;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle = 1'b0;
  logic clr = 1'b0;
  logic f_s, f_3, f_31, f_5;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  idle_duration_timer #(.PRE_DIV(P), .MID_DIV(M)) dut_i (
    .clk(clk), .rst_n(rst_n), .idle_long_i(idle), .clr_i(clr),
    .short_3ms_o(f_s), .over_3ms_o(f_3), .over_3p125ms_o(f_31), .over_5ms_o(f_5)
  );

  // Cycle model built from the requirements
  int m_pre, m_mid, m_cnt;
  logic e_s, e_3, e_31, e_5;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre <= 0; m_mid <= 0; m_cnt <= 0;
      e_s <= 0; e_3 <= 0; e_31 <= 0; e_5 <= 0;
    end else begin
      e_s  <= m_cnt < 48;
      e_3  <= m_cnt > 48;
      e_31 <= m_cnt > 50;
      e_5  <= m_cnt > 80;
      if (!idle || clr) begin
        m_pre <= 0; m_mid <= 0; m_cnt <= 0;
      end else if (m_pre == P - 1) begin
        m_pre <= 0;
        if (m_mid == M - 1) begin
          m_mid <= 0;
          if (m_cnt < 255) m_cnt <= m_cnt + 1;
        end else m_mid <= m_mid + 1;
      end else m_pre <= m_pre + 1;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R5 short", f_s, e_s);
    chk("R6 over3", f_3, e_3);
    chk("R7 over3p125", f_31, e_31);
    chk("R8 over5", f_5, e_5);
  endtask

  task automatic step(input logic i, input logic c);
    idle = i; clr = c;
    @(negedge clk);
    chk_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R9 reset short", f_s, 1'b0);
    chk("R9 reset over5", f_5, 1'b0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    // R1 R2: exact rise clock of the 3.0 ms flag
    idle = 1'b1;
    for (int n = 1; n <= 49 * T + 1; n++) begin
      @(negedge clk);
      chk_all();
      if (n == 49 * T) chk("R1 R2 over3 not yet", f_3, 1'b0);
      if (n == 49 * T + 1) chk("R1 R2 over3 rises", f_3, 1'b1);
    end

    // R3: saturation far past 255 ticks
    for (int n = 0; n < 300 * T; n++) step(1'b1, 1'b0);
    chk("R3 saturated short", f_s, 1'b0);
    chk("R3 saturated over5", f_5, 1'b1);

    // R4: clear pulse restarts from zero
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk("R4 clear short", f_s, 1'b1);
    chk("R4 clear over3", f_3, 1'b0);
    for (int n = 0; n < 60 * T; n++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk("R4 qualifier drop short", f_s, 1'b1);

    // Random segments
    for (int n = 0; n < 40000; n++) begin
      logic ci, ii;
      ci = ($urandom % 3000) == 0;
      ii = ($urandom % 2500) != 0;
      step(ii, ci);
    end

    // R9: asynchronous reset mid-run
    for (int n = 0; n < 90 * T; n++) step(1'b1, 1'b0);
    chk("R8 before reset", f_5, 1'b1);
    #2 rst_n = 1'b0;
    #1;
    chk("R9 async over5", f_5, 1'b0);
    chk("R9 async over3", f_3, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0);
    chk("R9 restart short", f_s, 1'b1);
    for (int n = 0; n < 2 * T; n++) step(1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule